// File: doc/BRIEF.md
# Transmit Phase-Align FIFO

This block sits between the parallel transmit logic and a 16:1 serializer. A 16-bit word is captured on every rising edge of the write clock, which is the transmit input clock, and one word leaves on every rising edge of the read clock, which is the internal character clock. The two clocks have the same frequency but an unknown and slowly drifting phase. A four-entry ring absorbs that drift. Bit 15 of each word is the most significant bit and is the first bit to go out on the line.

An asynchronous active-low reset clears the ring. While the reset is low, the output holds an alternating filler word. Releasing the reset fixes the phase: the write pointer starts two entries ahead of the read pointer, which leaves about half a character of slack in each direction. Pointers cross between the clock domains as Gray code through flop synchronisers.

When the read side finds the ring empty (underflow), or the write side finds it full (overflow), the fault output rises. The block then runs its own internal reset. For nine read-clock cycles the pointers are held at their starting positions and the output shows the filler word. After that the fault drops and data flows again with the pointers re-centred.

Top module: `txphase_fifo`

## Requirements
- R1: Each 16-bit wr_data word sampled on a rising wr_clk edge appears unchanged on rd_data, one word per rd_clk cycle, in write order, with bit 15 as the most significant bit.
- R2: After the reset is released, the first two rd_clk cycles deliver the filler word. The third cycle delivers the first word written after the release, because the pointers start two entries apart in a four-entry ring.
- R3: While rst_n is low, which acts asynchronously, rd_data equals the filler 16'hAAAA (bit 15 = 1, alternating downward) and fault is 0.
- R4: A shift of the write clock by up to half a character period after the release raises no fault and keeps the data stream intact.
- R5: If the write clock stalls for four cycles while reads continue (underflow), fault goes to 1.
- R6: If the read clock stalls for four cycles while writes continue (overflow), fault goes to 1.
- R7: Once raised, fault stays at 1 for exactly 9 rd_clk cycles and then returns to 0 by itself. While fault is 1, rd_data equals 16'hAAAA.
- R8: The automatic clear re-centres the pointers. After fault drops it stays at 0, and the word being written reaches rd_data again within 12 rd_clk cycles.
- R9: Driving rst_n low while fault is 1 clears fault at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Transmit input clock; wr_data is captured on its rising edge |
| rd_clk | input | 1 | Character clock toward the serializer |
| rst_n | input | 1 | Asynchronous active-low reset; its release sets the working phase |
| wr_data | input | 16 | Registered transmit word |
| rd_data | output | 16 | Word for the serializer; bit 15 is sent first |
| fault | output | 1 | Underflow or overflow seen; held high during the nine-cycle self clear |

## Verification
The stream is driven with three word patterns. An incrementing count shows that words are not dropped, repeated or reordered. A rotation of all-ones, all-zeros and the two alternating words exposes stuck or swapped bits, and separates real data from the filler. A multiplicative hash spreads values so that any mix-up between ring slots shows. Stalling one clock at a time separates underflow from overflow. A one-nanosecond write-clock slip during streaming confirms that drift inside the margin stays silent.

// File: rtl/txpa_pkg.sv
package txpa_pkg;

   typedef enum logic {
      CLR_IDLE = 1'b0,
      CLR_BUSY = 1'b1
   } clr_state_t;

   // filler bit at position idx: the top bit is 1, then alternating downward
   function automatic logic alt_bit(input int width, input int idx);
      return ((width - 1 - idx) % 2) == 0;
   endfunction

   function automatic int gray_of(input int v);
      return v ^ (v >> 1);
   endfunction

endpackage

// File: rtl/txpa_gray_sync.sv
module txpa_gray_sync #(
   parameter int PW     = 4,
   parameter int STAGES = 2,
   parameter int HEAD   = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_in,
   output logic [PW-1:0] gray_out
);
   localparam int MASK = (1 << PW) - 1;

   logic [PW-1:0] stage [STAGES];

   // each stage resets to the pointer value it would hold in steady flow
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++)
            stage[s] <= PW'(txpa_pkg::gray_of((HEAD - s - 1) & MASK));
      end else begin
         stage[0] <= gray_in;
         for (int s = 1; s < STAGES; s++)
            stage[s] <= stage[s-1];
      end
   end

   assign gray_out = stage[STAGES-1];
endmodule

// File: rtl/txpa_wr_side.sv
module txpa_wr_side #(
   parameter int               WIDTH = 16,
   parameter int               DEPTH = 4,
   parameter int               AW    = 2,
   parameter int               PW    = 4,
   parameter int               LAG   = 2,
   parameter int               START = 2,
   parameter logic [WIDTH-1:0] PAT   = '0
) (
   input  logic             wr_clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_word,
   output logic [PW-1:0]    wr_gray,
   input  logic [PW-1:0]    rd_gray_s,
   output logic             ovf_flag
);
   localparam logic [PW-1:0]        START_V = PW'(START);
   localparam logic [PW-1:0]        START_G = PW'(txpa_pkg::gray_of(START));
   localparam logic [PW-1:0]        LAG_V   = PW'(LAG);
   localparam logic signed [PW-1:0] FULL_S  = PW'(DEPTH);

   logic [WIDTH-1:0]        ring [DEPTH];
   logic [PW-1:0]           wbin, wbin_nxt, rs_bin;
   logic signed [PW-1:0]    fill;
   logic                    ovf_now;

   always_comb begin
      for (int i = 0; i < PW; i++)
         rs_bin[i] = ^(rd_gray_s >> i);
   end

   assign wbin_nxt = wbin + 1'b1;
   // estimated occupancy seen from this side, corrected for synchroniser lag
   assign fill     = wbin - rs_bin - LAG_V;
   assign ovf_now  = fill >= FULL_S;

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin     <= START_V;
         wr_gray  <= START_G;
         ovf_flag <= 1'b0;
         for (int i = 0; i < DEPTH; i++)
            ring[i] <= PAT;
      end else begin
         ring[wbin[AW-1:0]] <= wr_data;
         wbin               <= wbin_nxt;
         wr_gray            <= wbin_nxt ^ (wbin_nxt >> 1);
         if (ovf_now)
            ovf_flag <= 1'b1;
      end
   end

   assign rd_word = ring[rd_addr];
endmodule

// File: rtl/txpa_rd_side.sv
module txpa_rd_side #(
   parameter int               WIDTH = 16,
   parameter int               AW    = 2,
   parameter int               PW    = 4,
   parameter int               LAG   = 2,
   parameter logic [WIDTH-1:0] PAT   = '0
) (
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic [PW-1:0]    wr_gray_s,
   input  logic [WIDTH-1:0] rd_word,
   output logic [AW-1:0]    rd_addr,
   output logic [PW-1:0]    rd_gray,
   output logic [WIDTH-1:0] rd_data,
   output logic             udf
);
   localparam logic [PW-1:0]        LAG_V = PW'(LAG);
   localparam logic signed [PW-1:0] ONE_S = PW'(1);

   logic [PW-1:0]        rbin, rbin_nxt, ws_bin;
   logic signed [PW-1:0] ahead;

   always_comb begin
      for (int i = 0; i < PW; i++)
         ws_bin[i] = ^(wr_gray_s >> i);
   end

   assign rbin_nxt = rbin + 1'b1;
   assign ahead    = ws_bin + LAG_V - rbin;
   assign udf      = ahead < ONE_S;
   assign rd_addr  = rbin[AW-1:0];

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rd_gray <= '0;
         rd_data <= PAT;
      end else begin
         rd_data <= rd_word;
         rbin    <= rbin_nxt;
         rd_gray <= rbin_nxt ^ (rbin_nxt >> 1);
      end
   end
endmodule

// File: rtl/txpa_clear_ctl.sv
module txpa_clear_ctl #(
   parameter int CLEAR_CYCLES = 9,
   parameter int SYNC_STAGES  = 2
) (
   input  logic rd_clk,
   input  logic rst_n,
   input  logic ptr_rst_n,
   input  logic udf,
   input  logic ovf_wr,
   output logic fault
);
   import txpa_pkg::*;

   localparam int             CW   = $clog2(CLEAR_CYCLES + 1);
   localparam logic [CW-1:0]  LOAD = CW'(CLEAR_CYCLES - 1);

   logic [SYNC_STAGES-1:0] ovf_s;
   clr_state_t             state;
   logic [CW-1:0]          left;

   always_ff @(posedge rd_clk or negedge ptr_rst_n) begin
      if (!ptr_rst_n) ovf_s <= '0;
      else            ovf_s <= {ovf_s[SYNC_STAGES-2:0], ovf_wr};
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CLR_IDLE;
         left  <= '0;
      end else begin
         unique case (state)
            CLR_IDLE: if (udf || ovf_s[SYNC_STAGES-1]) begin
               state <= CLR_BUSY;
               left  <= LOAD;
            end
            CLR_BUSY: if (left == '0) state <= CLR_IDLE;
                      else            left  <= left - 1'b1;
         endcase
      end
   end

   assign fault = (state == CLR_BUSY);
endmodule

// File: rtl/txphase_fifo.sv
module txphase_fifo #(
   parameter int WIDTH        = 16,
   parameter int DEPTH        = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int CLEAR_CYCLES = 9
) (
   input  logic             wr_clk,
   input  logic             rd_clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data,
   output logic             fault
);
   localparam int AW    = $clog2(DEPTH);
   localparam int PW    = AW + 2;
   localparam int START = DEPTH / 2;

   function automatic logic [WIDTH-1:0] filler_word();
      logic [WIDTH-1:0] f;
      f = '0;
      for (int i = 0; i < WIDTH; i++)
         f[i] = txpa_pkg::alt_bit(WIDTH, i);
      return f;
   endfunction

   localparam logic [WIDTH-1:0] PAT = filler_word();

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("txphase_fifo: DEPTH must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("txphase_fifo: SYNC_STAGES must be at least 2");
      end
      if (CLEAR_CYCLES < 1) begin : g_bad_clear
         $error("txphase_fifo: CLEAR_CYCLES must be at least 1");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("txphase_fifo: WIDTH must be at least 2");
      end
   endgenerate

   logic             ptr_rst_n;
   logic [PW-1:0]    wr_gray, wr_gray_s, rd_gray, rd_gray_s;
   logic [AW-1:0]    rd_addr;
   logic [WIDTH-1:0] rd_word;
   logic             ovf_flag, udf;

   // the self clear reuses the pointer reset, so it re-centres both sides
   assign ptr_rst_n = rst_n & ~fault;

   txpa_wr_side #(
      .WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .PW(PW),
      .LAG(SYNC_STAGES), .START(START), .PAT(PAT)
   ) u_wr (
      .wr_clk   (wr_clk),
      .rst_n    (ptr_rst_n),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_word  (rd_word),
      .wr_gray  (wr_gray),
      .rd_gray_s(rd_gray_s),
      .ovf_flag (ovf_flag)
   );

   txpa_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES), .HEAD(0)) u_rd2wr (
      .clk     (wr_clk),
      .rst_n   (ptr_rst_n),
      .gray_in (rd_gray),
      .gray_out(rd_gray_s)
   );

   txpa_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES), .HEAD(START)) u_wr2rd (
      .clk     (rd_clk),
      .rst_n   (ptr_rst_n),
      .gray_in (wr_gray),
      .gray_out(wr_gray_s)
   );

   txpa_rd_side #(
      .WIDTH(WIDTH), .AW(AW), .PW(PW), .LAG(SYNC_STAGES), .PAT(PAT)
   ) u_rd (
      .rd_clk   (rd_clk),
      .rst_n    (ptr_rst_n),
      .wr_gray_s(wr_gray_s),
      .rd_word  (rd_word),
      .rd_addr  (rd_addr),
      .rd_gray  (rd_gray),
      .rd_data  (rd_data),
      .udf      (udf)
   );

   txpa_clear_ctl #(.CLEAR_CYCLES(CLEAR_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_clr (
      .rd_clk   (rd_clk),
      .rst_n    (rst_n),
      .ptr_rst_n(ptr_rst_n),
      .udf      (udf),
      .ovf_wr   (ovf_flag),
      .fault    (fault)
   );
endmodule

// File: rtl/txphase_fifo_chk.sv
module txphase_fifo_chk #(
   parameter int WIDTH        = 16,
   parameter int CLEAR_CYCLES = 9
) (
   input logic             rd_clk,
   input logic             rst_n,
   input logic             fault,
   input logic [WIDTH-1:0] rd_data
);
   localparam int HW = $clog2(CLEAR_CYCLES + 1) + 1;
   localparam logic [HW-1:0] LIM = HW'(CLEAR_CYCLES - 1);

   function automatic logic [WIDTH-1:0] expect_filler();
      logic [WIDTH-1:0] f;
      f = '0;
      for (int i = 0; i < WIDTH; i++)
         f[i] = txpa_pkg::alt_bit(WIDTH, i);
      return f;
   endfunction

   localparam logic [WIDTH-1:0] PAT = expect_filler();

   logic [HW-1:0] hi_cnt;

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)     hi_cnt <= '0;
      else if (fault) hi_cnt <= hi_cnt + 1'b1;
      else            hi_cnt <= '0;
   end

   // R7
   filler_in_clear_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      fault |-> rd_data == PAT);

   // R7
   clear_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (fault && hi_cnt < LIM) |=> fault);

   // R7
   clear_drop_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (fault && hi_cnt == LIM) |=> !fault);

   // R8
   recentre_quiet_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $fell(fault) |=> !fault);
endmodule

bind txphase_fifo txphase_fifo_chk #(
   .WIDTH(WIDTH), .CLEAR_CYCLES(CLEAR_CYCLES)
) u_chk (
   .rd_clk (rd_clk),
   .rst_n  (rst_n),
   .fault  (fault),
   .rd_data(rd_data)
);

// File: tb/txphase_fifo_bench.sv
`timescale 1ns/1ps
module txphase_fifo_bench;
   localparam logic [15:0] PAT = 16'hAAAA;

   logic        wr_clk, rd_clk, rst_n, fault;
   logic [15:0] wr_data, rd_data;
   bit          w_run = 1'b1, r_run = 1'b1, done = 1'b0;
   int          w_slip = 0;
   int          checks = 0, failures = 0;
   logic [15:0] exp_q[$];

   txphase_fifo u_txphase_fifo (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_data(wr_data), .rd_data(rd_data), .fault(fault)
   );

   // 250 MHz read clock: rising edges at 2, 6, 10 ns
   initial begin
      rd_clk = 1'b0;
      forever begin
         #2;
         if (r_run || rd_clk) rd_clk = ~rd_clk;
      end
   end

   // write clock, half a period behind, with stall and slip controls
   initial begin
      wr_clk = 1'b0;
      #2;
      forever begin
         #2;
         if (w_slip != 0) begin #(w_slip); w_slip = 0; end
         if (w_run || wr_clk) wr_clk = ~wr_clk;
      end
   end

   task automatic check_eq(input string req, input string what,
                           input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] gen_word(input int kind, input int i);
      logic [15:0] w;
      case (kind)
         0:       w = 16'(i * 257 + 1);
         1:       case (i % 4)
                     0: w = 16'hFFFF;
                     1: w = 16'h0000;
                     2: w = 16'h5555;
                     default: w = 16'hAAAA;
                  endcase
         default: w = 16'(i * 40503) ^ 16'hC3A5;
      endcase
      return w;
   endfunction

   task automatic hold_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge rd_clk);
      check_eq("R3", "rd_data in reset", rd_data, PAT);
      check_eq("R3", "fault in reset", {15'd0, fault}, 16'd0);
   endtask

   task automatic release_reset();
      @(negedge rd_clk);
      #1 rst_n = 1'b1;
   endtask

   // driver: pushes each word it presents before the wr_clk edge that captures it
   task automatic drive_words(input int n, input int kind);
      for (int i = 0; i < n; i++) begin
         wr_data = gen_word(kind, i);
         exp_q.push_back(wr_data);
         @(posedge wr_clk);
         #1;
      end
   endtask

   // monitor: two filler reads after release, then the words in order
   task automatic watch_words(input int n, input string fault_req);
      for (int k = 0; k < n + 2; k++) begin
         @(negedge rd_clk);
         if (k < 2) check_eq("R2", "filler after release", rd_data, PAT);
         else       check_eq("R1", "streamed word", rd_data, exp_q.pop_front());
         if (k % 4 == 3) check_eq(fault_req, "no fault while streaming", {15'd0, fault}, 16'd0);
      end
   endtask

   task automatic run_stream(input int n, input int kind, input string fault_req);
      fork
         drive_words(n + 4, kind);
         watch_words(n, fault_req);
      join
      exp_q.delete();
   endtask

   task automatic catch_fault(input string req, input bit count, output int hi);
      bit seen = 1'b0;
      hi = 0;
      for (int i = 0; i < 40 && !seen; i++) begin
         @(negedge rd_clk);
         if (fault) seen = 1'b1;
      end
      check_eq(req, "fault raised", {15'd0, seen}, 16'd1);
      if (seen && count) begin
         hi = 1;
         check_eq("R7", "filler during clear", rd_data, PAT);
         for (int j = 0; j < 40; j++) begin
            @(negedge rd_clk);
            if (!fault) break;
            hi++;
            check_eq("R7", "filler during clear", rd_data, PAT);
         end
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int hi;
      rst_n   = 1'b0;
      wr_data = 16'h0000;
      repeat (4) @(negedge rd_clk);

      // R1 R2: incrementing words
      hold_reset();
      release_reset();
      run_stream(20, 0, "R1");

      // R1 R2: complementary extremes and the filler value itself
      hold_reset();
      release_reset();
      run_stream(20, 1, "R1");

      // R4: hashed words with a 1 ns write-clock slip mid-stream
      hold_reset();
      release_reset();
      fork
         run_stream(40, 2, "R4");
         begin
            repeat (12) @(posedge rd_clk);
            w_slip = 1;
         end
      join
      hold_reset();
      w_slip = 3;  // back to the original alignment
      repeat (4) @(negedge rd_clk);

      // R5 R7 R8: write clock stalls, automatic clear, recovery
      wr_data = 16'h1234;
      hold_reset();
      release_reset();
      repeat (10) @(negedge rd_clk);
      check_eq("R5", "no fault before stall", {15'd0, fault}, 16'd0);
      fork
         begin
            w_run = 1'b0;
            #16;
            w_run = 1'b1;
         end
         catch_fault("R5", 1'b1, hi);
      join
      check_eq("R7", "fault high cycles", 16'(hi), 16'd9);
      for (int i = 0; i < 12; i++) begin
         @(negedge rd_clk);
         if (i % 3 == 0) check_eq("R8", "fault stays low after clear", {15'd0, fault}, 16'd0);
      end
      check_eq("R8", "data flows after clear", rd_data, 16'h1234);

      // R6 R9: read clock stalls, then external reset during the fault
      wr_data = 16'h0F0F;
      hold_reset();
      release_reset();
      repeat (10) @(negedge rd_clk);
      check_eq("R6", "data before stall", rd_data, 16'h0F0F);
      fork
         begin
            @(negedge rd_clk);
            r_run = 1'b0;
            #16;
            r_run = 1'b1;
         end
         catch_fault("R6", 1'b0, hi);
      join
      #1 rst_n = 1'b0;
      #1;
      check_eq("R9", "fault cleared by reset", {15'd0, fault}, 16'd0);
      check_eq("R3", "filler right after reset", rd_data, PAT);
      repeat (3) @(negedge rd_clk);
      check_eq("R9", "fault stays clear in reset", {15'd0, fault}, 16'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule